// File: doc/BRIEF.md
# Signed Index Register Adder

This execution unit sits beside the index register file of a small 8-bit processor core. It keeps the two index registers (X and Y) and the four arithmetic flags (negative, zero, carry, overflow). When the core issues an add-to-index instruction, it supplies an operand byte that has already been fetched through the same addressing modes the compare-index instructions use (immediate, direct page or absolute). The unit sign-extends that byte and adds it to the chosen register. The carry flag is never used as an input, so a negative operand performs a subtraction and no separate subtract instruction is needed.

The unit works in two index widths. In narrow mode the registers are 8 bits wide, the high byte reads as zero, and all flags come from bit 7. In wide mode the sign-extended operand is added across all 16 bits and the flags come from bit 15. Other instructions in the core write the index registers through a plain load strobe. A load changes only the selected register and leaves the flags alone.

Top module: `idx_adder_top`

## Requirements
- R1: When reset is active (rstN low), X, Y and the flags N, Z, C and V all become 0.
- R2: An add with regSel=0 writes the sum to X at the next rising clock edge, and Y is left unchanged.
- R3: An add with regSel=1 writes the sum to Y at the next rising clock edge, and X is left unchanged.
- R4: The operand is a two's-complement byte sign-extended to the register width. For example, adding 0xFF to 0x0100 in wide mode gives 0x00FF.
- R5: The carryIn input has no effect on the sum or on any flag.
- R6: With wideMode=0, only the low 8 bits take part in the add, bits 15:8 of the written register become 0, and the flags are taken from the 8-bit result.
- R7: After an add, N equals the top bit of the result (bit 7 in narrow mode, bit 15 in wide mode), and Z is 1 exactly when the result is zero.
- R8: After an add, C equals the unsigned carry out of the top bit when the register value and the sign-extended operand are added.
- R9: After an add, V is 1 exactly when the register and the sign-extended operand have the same sign and the result's sign differs from it.
- R10: A load with addStrobe low writes loadData to the selected register, with bits 15:8 cleared when wideMode=0, and leaves every flag unchanged. If addStrobe and loadEn are both high, the add takes effect and the load is ignored.
- R11: In a cycle with neither addStrobe nor loadEn high, X, Y and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addStrobe | input | 1 | Execute an add-to-index this cycle |
| loadEn | input | 1 | Write loadData into the selected register |
| regSel | input | 1 | Target register: 0 selects X, 1 selects Y |
| wideMode | input | 1 | 1 selects 16-bit index mode, 0 selects 8-bit index mode |
| carryIn | input | 1 | Current carry flag from the core; ignored by the add |
| operand | input | 8 | Signed operand byte from the fetch path |
| loadData | input | 16 | Value for a register load |
| xReg | output | 16 | Current X register |
| yReg | output | 16 | Current Y register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |

## Verification
The assertions check, on every cycle, the properties that depend only on register isolation and timing:
- the register that was not selected keeps its value;
- an idle cycle holds all state;
- a narrow-mode write clears the high byte;
- a load leaves the flags alone;
- adding zero with carryIn set changes nothing.

The bench's directed scenarios are needed for the arithmetic itself. They cover sign extension of negative operands, carry out at the 8-bit and 16-bit boundaries, overflow in both directions, the zero flag, and priority of the add over a simultaneous load. Each of these is compared against values worked out by hand from the requirements.

// File: rtl/idx_adder_pkg.sv
package idx_adder_pkg;

  typedef struct packed {
    logic writeX;
    logic writeY;
    logic takeSum;
    logic setFlags;
  } idxStrobes_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } idxFlags_t;

endpackage

// File: rtl/idx_adder_ctrl.sv
module idx_adder_ctrl
  import idx_adder_pkg::*;
(
  input  logic        addStrobe,
  input  logic        loadEn,
  input  logic        regSel,
  output idxStrobes_t strobes
);

  logic anyWrite;

  always_comb begin
    anyWrite         = addStrobe | loadEn;
    // the add wins over a load issued in the same cycle
    strobes.takeSum  = addStrobe;
    strobes.setFlags = addStrobe;
    strobes.writeX   = anyWrite & ~regSel;
    strobes.writeY   = anyWrite & regSel;
  end

endmodule

// File: rtl/idx_adder_datapath.sv
module idx_adder_datapath
  import idx_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  idxStrobes_t       strobes,
  input  logic              regSel,
  input  logic              wideMode,
  input  logic              carryIn,
  input  logic [OP_W-1:0]   operand,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] xQ,
  output logic [DATA_W-1:0] yQ,
  output idxFlags_t         flagsQ
);

  localparam int EXT_W    = DATA_W - OP_W;
  localparam int NARROW_W = OP_W;

  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] opExt;
  logic [DATA_W:0]   sumWide;
  logic [NARROW_W:0] sumNarrow;
  logic [DATA_W-1:0] resVal;
  logic [DATA_W-1:0] loadMasked;
  logic [DATA_W-1:0] writeVal;
  idxFlags_t         flagsWide;
  idxFlags_t         flagsNarrow;
  idxFlags_t         flagsNext;

  always_comb begin
    srcVal    = regSel ? yQ : xQ;
    opExt     = {{EXT_W{operand[OP_W-1]}}, operand};
    // carry-in deliberately not an input to either adder
    sumWide   = {1'b0, srcVal} + {1'b0, opExt};
    sumNarrow = {1'b0, srcVal[NARROW_W-1:0]} + {1'b0, opExt[NARROW_W-1:0]};

    flagsWide.n = sumWide[DATA_W-1];
    flagsWide.z = (sumWide[DATA_W-1:0] == '0);
    flagsWide.c = sumWide[DATA_W];
    flagsWide.v = (srcVal[DATA_W-1] == opExt[DATA_W-1]) &&
                  (sumWide[DATA_W-1] != srcVal[DATA_W-1]);

    flagsNarrow.n = sumNarrow[NARROW_W-1];
    flagsNarrow.z = (sumNarrow[NARROW_W-1:0] == '0);
    flagsNarrow.c = sumNarrow[NARROW_W];
    flagsNarrow.v = (srcVal[NARROW_W-1] == operand[OP_W-1]) &&
                    (sumNarrow[NARROW_W-1] != srcVal[NARROW_W-1]);

    if (wideMode) begin
      resVal     = sumWide[DATA_W-1:0];
      flagsNext  = flagsWide;
      loadMasked = loadData;
    end else begin
      resVal     = {{EXT_W{1'b0}}, sumNarrow[NARROW_W-1:0]};
      flagsNext  = flagsNarrow;
      loadMasked = {{EXT_W{1'b0}}, loadData[NARROW_W-1:0]};
    end

    writeVal = strobes.takeSum ? resVal : loadMasked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xQ     <= '0;
      yQ     <= '0;
      flagsQ <= '0;
    end else begin
      if (strobes.writeX)   xQ     <= writeVal;
      if (strobes.writeY)   yQ     <= writeVal;
      if (strobes.setFlags) flagsQ <= flagsNext;
    end
  end

  // R2: a write aimed at X never disturbs Y
  assert_y_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeSum || strobes.writeX || strobes.writeY) && !regSel |=> yQ == $past(yQ));

  // R3: a write aimed at Y never disturbs X
  assert_x_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeSum || strobes.writeX || strobes.writeY) && regSel |=> xQ == $past(xQ));

  // R6: narrow-mode writes leave the high byte zero
  assert_narrow_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeX || strobes.writeY) && !wideMode |=>
      (($past(regSel) ? yQ[DATA_W-1:NARROW_W] : xQ[DATA_W-1:NARROW_W]) == '0));

  // R10: a plain load keeps the flags
  assert_load_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeX || strobes.writeY) && !strobes.takeSum |=> flagsQ == $past(flagsQ));

  // R11: idle cycle holds all state
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.writeX || strobes.writeY || strobes.setFlags) |=>
      (xQ == $past(xQ)) && (yQ == $past(yQ)) && (flagsQ == $past(flagsQ)));

  // R5: adding zero with carry set leaves the register as it was
  assert_no_carry_in_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeSum && carryIn && (operand == '0) && wideMode && !regSel |=>
      xQ == $past(xQ));

endmodule

// File: rtl/idx_adder_top.sv
module idx_adder_top
  import idx_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addStrobe,
  input  logic              loadEn,
  input  logic              regSel,
  input  logic              wideMode,
  input  logic              carryIn,
  input  logic [OP_W-1:0]   operand,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] xReg,
  output logic [DATA_W-1:0] yReg,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV
);

  idxStrobes_t strobes;
  idxFlags_t   flagsQ;

  idx_adder_ctrl u_ctrl (
    .addStrobe (addStrobe),
    .loadEn    (loadEn),
    .regSel    (regSel),
    .strobes   (strobes)
  );

  idx_adder_datapath #(.DATA_W(DATA_W), .OP_W(OP_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regSel   (regSel),
    .wideMode (wideMode),
    .carryIn  (carryIn),
    .operand  (operand),
    .loadData (loadData),
    .xQ       (xReg),
    .yQ       (yReg),
    .flagsQ   (flagsQ)
  );

  assign flagN = flagsQ.n;
  assign flagZ = flagsQ.z;
  assign flagC = flagsQ.c;
  assign flagV = flagsQ.v;

endmodule

// File: tb/tb_idx_adder_top.sv
module tb_idx_adder_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addStrobe = 1'b0;
  logic        loadEn = 1'b0;
  logic        regSel = 1'b0;
  logic        wideMode = 1'b1;
  logic        carryIn = 1'b0;
  logic [7:0]  operand = '0;
  logic [15:0] loadData = '0;
  logic [15:0] xReg, yReg;
  logic        flagN, flagZ, flagC, flagV;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  idx_adder_top dut (
    .clk(clk), .rstN(rstN), .addStrobe(addStrobe), .loadEn(loadEn),
    .regSel(regSel), .wideMode(wideMode), .carryIn(carryIn),
    .operand(operand), .loadData(loadData), .xReg(xReg), .yReg(yReg),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic checkState(input string req, input logic [15:0] expX,
                            input logic [15:0] expY, input logic [3:0] expF);
    testsRun++;
    if (xReg !== expX || yReg !== expY || {flagN, flagZ, flagC, flagV} !== expF) begin
      testsFailed++;
      $display("FAIL %s: x=%h y=%h nzcv=%b, expected x=%h y=%h nzcv=%b",
               req, xReg, yReg, {flagN, flagZ, flagC, flagV}, expX, expY, expF);
    end
  endtask

  task automatic doAdd(input logic sel, input logic [7:0] op, input logic wide,
                       input logic cin);
    @(negedge clk);
    regSel = sel; operand = op; wideMode = wide; carryIn = cin; addStrobe = 1'b1;
    @(negedge clk);
    addStrobe = 1'b0; carryIn = 1'b0;
  endtask

  task automatic doLoad(input logic sel, input logic [15:0] data, input logic wide);
    @(negedge clk);
    regSel = sel; loadData = data; wideMode = wide; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic testReset();
    checkState("R1 reset", 16'h0000, 16'h0000, 4'b0000);
  endtask

  task automatic testAddX();
    doLoad(1'b0, 16'h1234, 1'b1);
    doAdd(1'b0, 8'h05, 1'b1, 1'b0);
    checkState("R2 add to X", 16'h1239, 16'h0000, 4'b0000);
  endtask

  task automatic testAddY();
    doAdd(1'b1, 8'h10, 1'b1, 1'b0);
    checkState("R3 add to Y", 16'h1239, 16'h0010, 4'b0000);
  endtask

  task automatic testSignExt();
    doLoad(1'b1, 16'h0100, 1'b1);
    doAdd(1'b1, 8'hFF, 1'b1, 1'b0);
    checkState("R4 negative operand", 16'h1239, 16'h00FF, 4'b0010);
  endtask

  task automatic testCarryIn();
    doLoad(1'b0, 16'h0010, 1'b1);
    doAdd(1'b0, 8'h01, 1'b1, 1'b1);
    checkState("R5 carry-in ignored", 16'h0011, 16'h00FF, 4'b0000);
    doAdd(1'b0, 8'h00, 1'b1, 1'b1);
    checkState("R5 add zero with carry", 16'h0011, 16'h00FF, 4'b0000);
  endtask

  task automatic testNarrow();
    doLoad(1'b0, 16'hAB7F, 1'b1);
    doAdd(1'b0, 8'h01, 1'b0, 1'b0);
    checkState("R6 R9 narrow overflow", 16'h0080, 16'h00FF, 4'b1001);
    doLoad(1'b0, 16'h12FF, 1'b0);
    checkState("R6 R10 narrow load", 16'h00FF, 16'h00FF, 4'b1001);
    doAdd(1'b0, 8'h01, 1'b0, 1'b0);
    checkState("R8 R7 narrow carry out", 16'h0000, 16'h00FF, 4'b0110);
  endtask

  task automatic testWideOverflow();
    doLoad(1'b0, 16'h7FFF, 1'b1);
    doAdd(1'b0, 8'h01, 1'b1, 1'b0);
    checkState("R9 R7 positive overflow", 16'h8000, 16'h00FF, 4'b1001);
    doLoad(1'b1, 16'h8000, 1'b1);
    doAdd(1'b1, 8'hFF, 1'b1, 1'b0);
    checkState("R9 R8 negative overflow", 16'h8000, 16'h7FFF, 4'b0011);
  endtask

  task automatic testWrapZero();
    doLoad(1'b0, 16'hFFFF, 1'b1);
    doAdd(1'b0, 8'h01, 1'b1, 1'b0);
    checkState("R7 R8 wide wrap to zero", 16'h0000, 16'h7FFF, 4'b0110);
  endtask

  task automatic testLoadPriority();
    doLoad(1'b1, 16'h4321, 1'b1);
    checkState("R10 load keeps flags", 16'h0000, 16'h4321, 4'b0110);
    @(negedge clk);
    regSel = 1'b0; operand = 8'h02; wideMode = 1'b1; loadData = 16'h5555;
    addStrobe = 1'b1; loadEn = 1'b1;
    @(negedge clk);
    addStrobe = 1'b0; loadEn = 1'b0;
    checkState("R10 add beats load", 16'h0002, 16'h4321, 4'b0000);
  endtask

  task automatic testIdle();
    @(negedge clk);
    regSel = 1'b1; operand = 8'h80; carryIn = 1'b1; loadData = 16'hFFFF;
    repeat (3) @(negedge clk);
    carryIn = 1'b0;
    checkState("R11 idle hold", 16'h0002, 16'h4321, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAddX();
    testAddY();
    testSignExt();
    testCarryIn();
    testNarrow();
    testWideOverflow();
    testWrapZero();
    testLoadPriority();
    testIdle();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule